// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Drive Controller

This block sequences the two switches of a synchronous buck half-bridge from a single PWM command. It produces a high-side enable and a low-side enable. It never lets both be on together, and it places the dead time adaptively. Before a switch is enabled, the block waits for comparator flags that report the opposite gate, and the switch node, below threshold.

When PWM falls, the low-side turn-on waits for both the switch-node-low flag and the high-side-gate-low flag. A cycle-count timeout bounds this wait, so a shorted high-side switch cannot stall it. When PWM rises, the high-side turn-on waits for the low-side-gate-low flag, with no time limit.

Four override inputs act above the sequencer, in fixed priority order: crowbar, undervoltage lockout, shutdown and low-side disable. All inputs are asynchronous and pass through two-flop synchronisers before they are used.

Top module: `gd_nonoverlap_ctrl`

## Requirements
- R1: On a PWM fall the high-side drive goes low first. The low-side drive goes high only after the synchronised switch-node-low and high-side-gate-low flags are both 1, which is at the earliest one cycle after the high-side drive drops.
- R2: If those flags are not both 1, the low-side drive goes high exactly TIMEOUT_CYC cycles after the high-side drive dropped. The timer restarts on every PWM fall.
- R3: On a PWM rise the low-side drive goes low first. The high-side drive goes high only after the synchronised low-side-gate-low flag is 1. This wait has no time limit.
- R4: While crowbar (active high) is 1, the high-side drive is 0 and the low-side drive is 1, whatever the state of PWM, undervoltage, shutdown or low-side disable.
- R5: While crowbar is 0 and undervoltage lockout (active high) is 1, both drives are 0.
- R6: While crowbar and undervoltage are 0 and shutdown (active low) is 0, both drives are 0.
- R7: While low-side enable (active low disable) is 0, the low-side drive stays 0. The high-side drive still follows PWM with the normal waits.
- R8: The high-side and low-side drives are never 1 in the same cycle.
- R9: An input change reaches the drive outputs no earlier than the third rising clock edge after it, after two synchroniser flops and the state register.
- R10: When an override is released, both drives are 0 for at least one cycle. Sequencing then resumes from the current PWM level, under the normal wait rules of R1 to R3.
- R11: During reset (rst_n = 0), both drives are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM command, asynchronous |
| crowbar_in | input | 1 | Crowbar request, active high |
| uvlo_in | input | 1 | Undervoltage lockout active, active high |
| shdn_n_in | input | 1 | Shutdown, active low |
| ls_en_in | input | 1 | Low-side enable; 0 disables the low-side drive |
| sw_low_in | input | 1 | Switch node below threshold flag |
| hsg_low_in | input | 1 | High-side gate below threshold flag |
| lsg_low_in | input | 1 | Low-side gate below threshold flag |
| hs_drive | output | 1 | High-side gate enable |
| ls_drive | output | 1 | Low-side gate enable |

## Verification
Every input change takes effect at the third rising edge after it. That edge covers two synchroniser flops and the registered state with its outputs. A second flag-qualified transition lands one edge later, and a timeout-forced low-side turn-on lands TIMEOUT_CYC edges after the high-side drive drops. The bench drives inputs on falling edges and samples on falling edges. The table rows wait well past these latencies for steady-state results. The directed tests count edges one at a time and check both the cycle before and the cycle of each expected change.

// File: rtl/gd_pkg.sv
// Shared types for the non-overlap gate drive controller.
// Assumes: all control inputs are single-bit levels.
package gd_pkg;

    // Synchronised control bundle, one bit per asynchronous input
    typedef struct packed {
        logic pwm;
        logic crowbar;
        logic uvlo;
        logic shdn_n;
        logic ls_en;
        logic sw_low;
        logic hsg_low;
        logic lsg_low;
    } gd_ctl_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HS_ON   = 3'd1,
        ST_WAIT_LS = 3'd2,
        ST_LS_ON   = 3'd3,
        ST_WAIT_HS = 3'd4,
        ST_CROWBAR = 3'd5
    } gd_state_e;

endpackage

// File: rtl/gd_sync.sv
// Multi-bit level synchroniser: STAGES flops per bit, reset to zero.
// Assumes: each bit is an independent slow level; no bus coherency needed.
module gd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the level one flop further into the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gd_timeout.sv
// Low-side turn-on timeout counter.
// Counts cycles spent waiting after a start pulse. It flags expiry when
// the count reaches TIMEOUT_CYC-1, so the low side follows TIMEOUT_CYC
// cycles after the wait began.
// Assumes: TIMEOUT_CYC >= 2; start is a one-cycle pulse at wait entry.
module gd_timeout #(
    parameter int TIMEOUT_CYC = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    // Purpose: clear on wait entry, count up while waiting, saturate at limit
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (start)                 cnt <= '0;
        else if (run && (cnt != LIM))   cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LIM);
endmodule

// File: rtl/gd_seq.sv
// Sequencer: override priority plus adaptive non-overlap state machine.
// Priority: crowbar > undervoltage > shutdown > normal sequencing.
// Low-side disable only masks the low-side output.
// Assumes: all ctl inputs are already synchronised.
module gd_seq
    import gd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  gd_ctl_t   ctl,
    input  logic      tmo_exp,
    output logic      tmo_start,
    output logic      tmo_run,
    output gd_state_e st_q,
    output logic      hs_q,
    output logic      ls_q
);
    gd_state_e st_d;

    // Purpose: next state from overrides, PWM level and feedback flags
    always_comb begin
        st_d = st_q;
        if (ctl.crowbar) begin
            st_d = ST_CROWBAR;
        end else if (ctl.uvlo || !ctl.shdn_n) begin
            st_d = ST_OFF;
        end else begin
            case (st_q)
                ST_CROWBAR: st_d = ST_OFF;
                ST_OFF:     st_d = ctl.pwm ? ST_WAIT_HS : ST_WAIT_LS;
                ST_HS_ON:   st_d = ctl.pwm ? ST_HS_ON : ST_WAIT_LS;
                ST_WAIT_LS: begin
                    if (ctl.pwm)                                      st_d = ST_WAIT_HS;
                    else if ((ctl.sw_low && ctl.hsg_low) || tmo_exp) st_d = ST_LS_ON;
                    else                                              st_d = ST_WAIT_LS;
                end
                ST_LS_ON:   st_d = ctl.pwm ? ST_WAIT_HS : ST_LS_ON;
                ST_WAIT_HS: begin
                    if (!ctl.pwm)         st_d = ST_WAIT_LS;
                    else if (ctl.lsg_low) st_d = ST_HS_ON;
                    else                  st_d = ST_WAIT_HS;
                end
                default:    st_d = ST_OFF;
            endcase
        end
    end

    assign tmo_start = (st_d == ST_WAIT_LS) && (st_q != ST_WAIT_LS);
    assign tmo_run   = (st_q == ST_WAIT_LS);

    // Purpose: register state and glitch-free drive outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            st_q <= st_d;
            hs_q <= (st_d == ST_HS_ON);
            ls_q <= (st_d == ST_CROWBAR) || ((st_d == ST_LS_ON) && ctl.ls_en);
        end
    end
endmodule

// File: rtl/gd_nonoverlap_ctrl.sv
// Top: adaptive non-overlap gate drive controller.
// Synchronises all asynchronous inputs, then sequences the two drives.
// Assumes: clk is free-running; TIMEOUT_CYC is in clk cycles (>= 2).
module gd_nonoverlap_ctrl
    import gd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic crowbar_in,
    input  logic uvlo_in,
    input  logic shdn_n_in,
    input  logic ls_en_in,
    input  logic sw_low_in,
    input  logic hsg_low_in,
    input  logic lsg_low_in,
    output logic hs_drive,
    output logic ls_drive
);
    localparam int CTL_W = $bits(gd_ctl_t);

    gd_ctl_t          ctl_raw;
    gd_ctl_t          ctl_s;
    logic [CTL_W-1:0] ctl_s_bits;
    logic             tmo_start;
    logic             tmo_run;
    logic             tmo_exp;
    gd_state_e        st_q;

    assign ctl_raw = '{pwm: pwm_in, crowbar: crowbar_in, uvlo: uvlo_in,
                       shdn_n: shdn_n_in, ls_en: ls_en_in, sw_low: sw_low_in,
                       hsg_low: hsg_low_in, lsg_low: lsg_low_in};

    gd_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctl_raw),
        .q     (ctl_s_bits)
    );

    assign ctl_s = gd_ctl_t'(ctl_s_bits);

    gd_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmo_start),
        .run     (tmo_run),
        .expired (tmo_exp)
    );

    gd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl_s),
        .tmo_exp   (tmo_exp),
        .tmo_start (tmo_start),
        .tmo_run   (tmo_run),
        .st_q      (st_q),
        .hs_q      (hs_drive),
        .ls_q      (ls_drive)
    );
endmodule

// File: rtl/gd_nonoverlap_ctrl_chk.sv
// Assertion checker for gd_nonoverlap_ctrl, attached with bind.
// Relates synchronised inputs, timer expiry and state to the drive outputs.
module gd_nonoverlap_ctrl_chk
    import gd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input gd_ctl_t   ctl_s,
    input logic      tmo_exp,
    input gd_state_e st_q,
    input logic      hs_drive,
    input logic      ls_drive
);
    // R8: never both on
    assert_no_shoot_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_drive && ls_drive));

    // R4: crowbar forces low side on, high side off
    assert_crowbar_force_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_s.crowbar) |-> (!hs_drive && ls_drive));

    // R5: undervoltage without crowbar holds both off
    assert_uvlo_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_s.crowbar) && $past(ctl_s.uvlo)) |-> (!hs_drive && !ls_drive));

    // R6: shutdown without crowbar holds both off
    assert_shutdown_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ctl_s.crowbar) && !$past(ctl_s.shdn_n)) |-> (!hs_drive && !ls_drive));

    // R3: high side turns on only after low side off and its gate flag seen
    assert_hs_waits_lsg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drive) |-> ($past(ctl_s.lsg_low) && !$past(ls_drive)));

    // R1: outside crowbar, low side turns on only after high side already off
    assert_ls_after_hs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_drive) && !$past(ctl_s.crowbar)) |->
            (!$past(hs_drive) && (($past(ctl_s.sw_low) && $past(ctl_s.hsg_low)) || $past(tmo_exp))));

    // R7: outside crowbar, low side on only with enable seen
    assert_ls_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_drive && !$past(ctl_s.crowbar)) |-> $past(ctl_s.ls_en));

    // R2: expired timer in the low-side wait forces low side on
    assert_timeout_forces_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tmo_exp) && ($past(st_q) == ST_WAIT_LS) && !$past(ctl_s.pwm) &&
         !$past(ctl_s.crowbar) && !$past(ctl_s.uvlo) && $past(ctl_s.shdn_n) &&
         $past(ctl_s.ls_en)) |-> ls_drive);
endmodule

bind gd_nonoverlap_ctrl gd_nonoverlap_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_s    (ctl_s),
    .tmo_exp  (tmo_exp),
    .st_q     (st_q),
    .hs_drive (hs_drive),
    .ls_drive (ls_drive)
);

// File: tb/gd_nonoverlap_ctrl_tb.sv
`timescale 1ns/1ps
module gd_nonoverlap_ctrl_tb;
    localparam int TMO = 14;
    localparam int NV  = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 1'b0, cb = 1'b0, uv = 1'b0, sd_n = 1'b1, lsen = 1'b1;
    logic swl = 1'b1, hgl = 1'b1, lgl = 1'b1;
    logic hs, ls;
    int   total = 0, bad = 0, both_hi = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    gd_nonoverlap_ctrl #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .crowbar_in(cb), .uvlo_in(uv),
        .shdn_n_in(sd_n), .ls_en_in(lsen), .sw_low_in(swl), .hsg_low_in(hgl),
        .lsg_low_in(lgl), .hs_drive(hs), .ls_drive(ls)
    );

    // Row: {req[3:0], pwm,cb,uvlo,shdn_n,ls_en,sw_low,hsg_low,lsg_low, wait[7:0], exp_hs, exp_ls}
    localparam logic [21:0] VEC [NV] = '{
        {4'd1,  8'b00011111, 8'd6,  2'b01},  // R1 low phase
        {4'd3,  8'b10011111, 8'd6,  2'b10},  // R3 high phase
        {4'd1,  8'b00011111, 8'd6,  2'b01},  // R1
        {4'd3,  8'b10011110, 8'd8,  2'b00},  // R3 waiting on low-side gate flag
        {4'd3,  8'b10011111, 8'd6,  2'b10},  // R3 flag arrives
        {4'd1,  8'b00011011, 8'd5,  2'b00},  // R1 waiting on switch node
        {4'd1,  8'b00011111, 8'd6,  2'b01},  // R1 flags both true
        {4'd3,  8'b10011111, 8'd6,  2'b10},  // R3
        {4'd2,  8'b00011001, 8'd8,  2'b00},  // R2 before timeout
        {4'd2,  8'b00011001, 8'd12, 2'b01},  // R2 after timeout
        {4'd4,  8'b01011111, 8'd6,  2'b01},  // R4 crowbar
        {4'd4,  8'b11011111, 8'd6,  2'b01},  // R4 overrides PWM
        {4'd4,  8'b11100000, 8'd6,  2'b01},  // R4 overrides uvlo, shutdown, disable
        {4'd5,  8'b10111111, 8'd6,  2'b00},  // R5 undervoltage
        {4'd6,  8'b10001111, 8'd6,  2'b00},  // R6 shutdown
        {4'd10, 8'b10011111, 8'd6,  2'b10},  // R10 re-entry high
        {4'd7,  8'b00010111, 8'd6,  2'b00},  // R7 low side disabled
        {4'd7,  8'b10010111, 8'd6,  2'b10},  // R7 high side still follows
        {4'd7,  8'b00011111, 8'd6,  2'b01}   // R7 re-enabled
    };

    task automatic check(input string tag, input logic ehs, input logic els);
        total++;
        if (hs !== ehs || ls !== els) begin
            bad++;
            $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs, ls, ehs, els);
        end
    endtask

    task automatic drive(input logic [7:0] v);
        {pwm, cb, uv, sd_n, lsen, swl, hgl, lgl} = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Overlap monitor for R8
    always @(negedge clk) if (rst_n && hs && ls) both_hi++;

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: hs=%b ls=%b expected run to finish", hs, ls);
        finish_run();
    end

    initial begin
        // R11: outputs low in reset
        repeat (4) @(negedge clk);
        check("R11 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17:10]);
            repeat (int'(VEC[i][9:2])) @(negedge clk);
            check($sformatf("R%0d row %0d", VEC[i][21:18], i), VEC[i][1], VEC[i][0]);
        end

        // R9, R1: exact latency on flag-qualified low-side turn-on
        drive(8'b10011111); repeat (8) @(negedge clk);
        drive(8'b00011111);
        repeat (2) @(negedge clk); check("R9 no change before third edge", 1'b1, 1'b0);
        @(negedge clk);            check("R1 high side off first", 1'b0, 1'b0);
        @(negedge clk);            check("R1 low side one edge later", 1'b0, 1'b1);

        // R3: exact low-side off then high-side on
        drive(8'b10011111);
        repeat (3) @(negedge clk); check("R3 low side off first", 1'b0, 1'b0);
        @(negedge clk);            check("R3 high side one edge later", 1'b1, 1'b0);

        // R2: exact timeout edge
        drive(8'b00011001);
        repeat (3) @(negedge clk); check("R2 high side dropped", 1'b0, 1'b0);
        repeat (TMO - 1) @(negedge clk); check("R2 one cycle before timeout", 1'b0, 1'b0);
        @(negedge clk);            check("R2 timeout fires", 1'b0, 1'b1);

        // R3: no timeout on the high-side wait
        drive(8'b10011110);
        repeat (4 * TMO) @(negedge clk); check("R3 waits without limit", 1'b0, 1'b0);
        drive(8'b10011111); repeat (6) @(negedge clk);

        // R10: crowbar release with PWM low restarts safe, then waits flags
        drive(8'b01011001); repeat (6) @(negedge clk); check("R4 crowbar on", 1'b0, 1'b1);
        drive(8'b00011001);
        repeat (3) @(negedge clk); check("R10 safe state after release", 1'b0, 1'b0);
        repeat (4) @(negedge clk); check("R10 still waiting flags", 1'b0, 1'b0);
        drive(8'b00011111); repeat (4) @(negedge clk);
        check("R10 resumes low side", 1'b0, 1'b1);

        total++;
        if (both_hi != 0) begin
            bad++;
            $display("FAIL R8 overlap cycles: actual=%0d expected=0", both_hi);
        end
        finish_run();
    end
endmodule